// File: doc/BRIEF.md
# Dual-Framing Synchronous Serial Master

This block is a master-only synchronous serial port. Words are queued in an eight-entry transmit FIFO and shifted out most significant bit first. The bits that come back on the serial input are gathered into an eight-entry receive FIFO, right-justified. One shift engine drives either of two framings. In SPI framing (clock polarity 0, phase 0) an active-low select is held for the whole transfer. In SSI framing the clock also idles low, and a one-bit-long high frame pulse comes before every word.

The bit rate comes from two dividers in series: an even prescaler from 2 to 254, then a second divider of 0 to 255. This spans the system clock divided by 2 down to the system clock divided by 65024. Format, frame width and both divider values are register-style inputs. The block captures them only while it is disabled and idle, so software may change them at any time with no effect on a transfer already under way. A transmit-level interrupt asks for more data whenever the enabled port holds four or fewer queued words.

Top module: `sync_serial_master`

## Requirements
- R1: `cfg_width_m1` holds the frame width minus one, giving 4 to 16 bits. Values below 3 act as 3. Each word is sent most significant bit first, and bits above the frame width are never sent.
- R2: With `cfg_fmt`=0 (SPI), `sclk` idles low and `sdo` changes only on a falling edge. `sdi` is sampled on each rising edge. `frame_sel` is high when idle and low for the whole of every frame. It stays low across frames sent back to back, and rises only when the transmit FIFO has run empty.
- R3: With `cfg_fmt`=1 (SSI), `sclk` and `frame_sel` both idle low. `frame_sel` is high for exactly one bit period just before each word, and one extra `sclk` rising edge falls inside that pulse. `sdo` changes on rising edges and `sdi` is sampled on falling edges.
- R4: `sclk` toggles only while a frame is being transferred.
- R5: One bit period is P×(1+D) system clocks. P is `cfg_prescale` with bit 0 cleared, and a P of 0 acts as 2. D is `cfg_divider`.
- R6: A frame starts when the port is enabled and the transmit FIFO is not empty. This happens both when words are written to an enabled port and when the port is enabled with words already queued.
- R7: `tx_irq` is high exactly when `cfg_enable` is high and the transmit FIFO holds four or fewer words. It follows those conditions one clock later.
- R8: Format, width and divider inputs take effect only while `cfg_enable` is low and no frame is in progress. Changes made while the port is enabled are ignored.
- R9: Each FIFO holds 8 words. A write to a full transmit FIFO is dropped. The flags `st_tx_empty`, `st_tx_not_full`, `st_rx_not_empty` and `st_rx_full` report the FIFO levels, and `st_busy` is high while a frame is in progress.
- R10: Received frames are stored right-justified with zeros above the width. A one-cycle `rx_rd` pulse pops the oldest word into the registered `rx_data`, which is valid from the following cycle.
- R11: A frame that completes while the receive FIFO is full is discarded and sets `st_overrun`. The flag stays set until `ovr_clr` is pulsed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_enable | input | 1 | Port enable |
| cfg_fmt | input | 1 | Framing: 0 SPI, 1 SSI |
| cfg_width_m1 | input | 4 | Frame width minus one |
| cfg_prescale | input | 8 | Even prescaler value |
| cfg_divider | input | 8 | Second divider value |
| tx_wr | input | 1 | Push `tx_data` into the transmit FIFO |
| tx_data | input | 16 | Transmit word |
| rx_rd | input | 1 | Pop the receive FIFO into `rx_data` |
| rx_data | output | 16 | Last popped receive word |
| ovr_clr | input | 1 | Clear the overrun flag |
| sclk | output | 1 | Serial clock |
| frame_sel | output | 1 | SPI select (active low) or SSI frame pulse |
| sdo | output | 1 | Serial data out |
| sdi | input | 1 | Serial data in |
| st_tx_empty | output | 1 | Transmit FIFO empty |
| st_tx_not_full | output | 1 | Transmit FIFO has room |
| st_rx_not_empty | output | 1 | Receive FIFO holds data |
| st_rx_full | output | 1 | Receive FIFO full |
| st_busy | output | 1 | Frame in progress |
| st_overrun | output | 1 | Sticky receive overrun |
| tx_irq | output | 1 | Transmit level interrupt |

## Verification
The assertions assume the configuration inputs are changed only between transfers, or else left to the capture logic. They also assume `rx_rd` and `tx_wr` are single-cycle pulses driven away from the clock edge. The bench keeps to this by changing every input at the falling system-clock edge and by leaving several idle cycles after each configuration change before it enables the port. It loops `sdo` back to `sdi`, optionally inverted, so every received word is predictable. This bench loopback is the only source of serial input data.

// File: rtl/ssm_pkg.sv
package ssm_pkg;
  typedef enum logic {
    FMT_SPI = 1'b0,
    FMT_SSI = 1'b1
  } fmt_e;
endpackage

// File: rtl/ssm_fifo.sv
module ssm_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 8
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic [W-1:0]             wr_data,
  input  logic                     rd_en,
  output logic [W-1:0]             rd_data,
  output logic [$clog2(DEPTH):0]   count
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [AW:0]   cnt_q;
  logic          empty, full, do_wr, do_rd;

  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == (AW+1)'(DEPTH));
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;

  // storage: write port only, no reset, so RAM can be inferred
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp_q] <= wr_data;
  end

  assign rd_data = mem[rp_q];
  assign count   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_wr) wp_q <= wp_q + 1'b1;
      if (do_rd) rp_q <= rp_q + 1'b1;
      cnt_q <= cnt_q + {{AW{1'b0}}, do_wr} - {{AW{1'b0}}, do_rd};
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= (AW+1)'(DEPTH)); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    (empty && !wr_en) |=> (cnt_q == '0)); // R9
endmodule

// File: rtl/ssm_rate_gen.sv
module ssm_rate_gen #(
  parameter int PW = 8,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic [PW-1:0] half_pre,   // prescale / 2
  input  logic [DW-1:0] divider,
  output logic          tick        // one pulse per half bit period
);
  logic [PW-1:0] pre_lim;
  logic [PW-1:0] pre_cnt_q;
  logic [DW-1:0] div_cnt_q;
  logic          pre_wrap;

  // a prescale of zero behaves as two
  assign pre_lim  = (half_pre == '0) ? '0 : half_pre - 1'b1;
  assign pre_wrap = (pre_cnt_q == pre_lim);
  assign tick     = run && pre_wrap && (div_cnt_q == divider);

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      pre_cnt_q <= '0;
      div_cnt_q <= '0;
    end else if (pre_wrap) begin
      pre_cnt_q <= '0;
      div_cnt_q <= (div_cnt_q == divider) ? '0 : div_cnt_q + 1'b1;
    end else begin
      pre_cnt_q <= pre_cnt_q + 1'b1;
    end
  end

  AST_PRE_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> (pre_cnt_q <= pre_lim)); // R5
  AST_DIV_RANGE: assert property (@(posedge clk) disable iff (rst)
    run |-> (div_cnt_q <= divider)); // R5
endmodule

// File: rtl/ssm_shift_engine.sv
module ssm_shift_engine
  import ssm_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int WW     = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  fmt_e              fmt,
  input  logic [WW-1:0]     width_m1,
  input  logic              tick,
  input  logic              tx_avail,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              sdi,
  output logic              load,
  output logic              rx_push,
  output logic [DATA_W-1:0] rx_word,
  output logic              active,
  output logic              sclk,
  output logic              frame_sel,
  output logic              sdo
);
  localparam int HW = $clog2(2*DATA_W+2);

  logic              active_q, sclk_q, sel_q, sdo_q;
  logic [HW-1:0]     half_q, nbits, last_half, next_half;
  logic [DATA_W-1:0] sh_q, rx_q, aligned;
  logic [WW-1:0]     sh_amt;
  logic              is_ssi, frame_end;

  assign is_ssi  = (fmt == FMT_SSI);
  assign sh_amt  = WW'(DATA_W-1) - width_m1;
  assign aligned = tx_word << sh_amt;

  always_comb begin
    nbits     = HW'(width_m1) + HW'(1);
    last_half = is_ssi ? (nbits << 1) + HW'(1) : (nbits << 1) - HW'(1);
    next_half = half_q + HW'(1);
  end

  assign frame_end = active_q && tick && (half_q == last_half);
  assign load      = tx_avail && (!active_q || frame_end);
  assign rx_push   = frame_end;
  assign rx_word   = rx_q;
  assign active    = active_q;
  assign sclk      = sclk_q;
  assign frame_sel = sel_q;
  assign sdo       = sdo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      half_q   <= '0;
      sh_q     <= '0;
      rx_q     <= '0;
      sclk_q   <= 1'b0;
      sel_q    <= 1'b1;
      sdo_q    <= 1'b0;
    end else if (load) begin
      active_q <= 1'b1;
      half_q   <= '0;
      rx_q     <= '0;
      if (is_ssi) begin
        sclk_q <= 1'b1;          // sync bit: pulse high, clock rises
        sel_q  <= 1'b1;
        sdo_q  <= 1'b0;
        sh_q   <= aligned;
      end else begin
        sclk_q <= 1'b0;
        sel_q  <= 1'b0;
        sdo_q  <= aligned[DATA_W-1];
        sh_q   <= aligned << 1;
      end
    end else if (frame_end) begin
      active_q <= 1'b0;
      half_q   <= '0;
      sclk_q   <= 1'b0;
      sel_q    <= !is_ssi;
      sdo_q    <= 1'b0;
    end else if (active_q && tick) begin
      half_q <= next_half;
      if (is_ssi) begin
        if (next_half[0]) begin
          sclk_q <= 1'b0;
          if (next_half >= HW'(3)) rx_q <= {rx_q[DATA_W-2:0], sdi};
        end else begin
          sclk_q <= 1'b1;
          sel_q  <= 1'b0;
          sdo_q  <= sh_q[DATA_W-1];
          sh_q   <= sh_q << 1;
        end
      end else begin
        if (next_half[0]) begin
          sclk_q <= 1'b1;
          rx_q   <= {rx_q[DATA_W-2:0], sdi};
        end else begin
          sclk_q <= 1'b0;
          sdo_q  <= sh_q[DATA_W-1];
          sh_q   <= sh_q << 1;
        end
      end
    end else if (!active_q) begin
      sel_q  <= !is_ssi;
      sclk_q <= 1'b0;
      sdo_q  <= 1'b0;
    end
  end

  AST_SCLK_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!active_q && !load) |=> !sclk_q); // R4
  AST_SCLK_ON_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick && !load) |=> $stable(sclk_q)); // R5
  AST_SPI_SEL_LOW: assert property (@(posedge clk) disable iff (rst)
    (active_q && !is_ssi) |-> !sel_q); // R2
  AST_HALF_RANGE: assert property (@(posedge clk) disable iff (rst)
    active_q |-> (half_q <= last_half)); // R1
endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
  import ssm_pkg::*;
#(
  parameter int DATA_W     = 16,
  parameter int FIFO_DEPTH = 8,
  parameter int IRQ_LEVEL  = 4,
  parameter int PRE_W      = 8,
  parameter int DIV_W      = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        cfg_enable,
  input  logic                        cfg_fmt,
  input  logic [$clog2(DATA_W)-1:0]   cfg_width_m1,
  input  logic [PRE_W-1:0]            cfg_prescale,
  input  logic [DIV_W-1:0]            cfg_divider,
  input  logic                        tx_wr,
  input  logic [DATA_W-1:0]           tx_data,
  input  logic                        rx_rd,
  output logic [DATA_W-1:0]           rx_data,
  input  logic                        ovr_clr,
  output logic                        sclk,
  output logic                        frame_sel,
  output logic                        sdo,
  input  logic                        sdi,
  output logic                        st_tx_empty,
  output logic                        st_tx_not_full,
  output logic                        st_rx_not_empty,
  output logic                        st_rx_full,
  output logic                        st_busy,
  output logic                        st_overrun,
  output logic                        tx_irq
);
  localparam int WW = $clog2(DATA_W);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  fmt_e              fmt_q;
  logic [WW-1:0]     width_q;
  logic [PRE_W-1:0]  half_pre_q;
  logic [DIV_W-1:0]  div_q;

  logic [CW-1:0]     tx_cnt, rx_cnt;
  logic [DATA_W-1:0] tx_head, rx_head, rx_word, rx_data_q;
  logic              load, rx_push, active, tick;
  logic              tx_empty, rx_empty, rx_full;
  logic              ovr_q, irq_q;

  // configuration capture: only while disabled and idle
  always_ff @(posedge clk) begin
    if (rst) begin
      fmt_q      <= FMT_SPI;
      width_q    <= WW'(7);
      half_pre_q <= PRE_W'(1);
      div_q      <= '0;
    end else if (!cfg_enable && !active) begin
      fmt_q      <= fmt_e'(cfg_fmt);
      width_q    <= (cfg_width_m1 < WW'(3)) ? WW'(3) : cfg_width_m1;
      half_pre_q <= cfg_prescale >> 1;
      div_q      <= cfg_divider;
    end
  end

  ssm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_tx_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (tx_wr),
    .wr_data (tx_data),
    .rd_en   (load),
    .rd_data (tx_head),
    .count   (tx_cnt)
  );

  ssm_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) i_rx_fifo (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (rx_push && !rx_full),
    .wr_data (rx_word),
    .rd_en   (rx_rd),
    .rd_data (rx_head),
    .count   (rx_cnt)
  );

  assign tx_empty = (tx_cnt == '0);
  assign rx_empty = (rx_cnt == '0);
  assign rx_full  = (rx_cnt == CW'(FIFO_DEPTH));

  ssm_rate_gen #(.PW(PRE_W), .DW(DIV_W)) i_rate (
    .clk      (clk),
    .rst      (rst),
    .run      (active),
    .half_pre (half_pre_q),
    .divider  (div_q),
    .tick     (tick)
  );

  ssm_shift_engine #(.DATA_W(DATA_W), .WW(WW)) i_shift (
    .clk       (clk),
    .rst       (rst),
    .fmt       (fmt_q),
    .width_m1  (width_q),
    .tick      (tick),
    .tx_avail  (cfg_enable && !tx_empty),
    .tx_word   (tx_head),
    .sdi       (sdi),
    .load      (load),
    .rx_push   (rx_push),
    .rx_word   (rx_word),
    .active    (active),
    .sclk      (sclk),
    .frame_sel (frame_sel),
    .sdo       (sdo)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data_q <= '0;
      ovr_q     <= 1'b0;
      irq_q     <= 1'b0;
    end else begin
      if (rx_rd && !rx_empty) rx_data_q <= rx_head;
      if (rx_push && rx_full) ovr_q <= 1'b1;
      else if (ovr_clr)       ovr_q <= 1'b0;
      irq_q <= cfg_enable && (tx_cnt <= CW'(IRQ_LEVEL));
    end
  end

  assign rx_data         = rx_data_q;
  assign st_tx_empty     = tx_empty;
  assign st_tx_not_full  = (tx_cnt != CW'(FIFO_DEPTH));
  assign st_rx_not_empty = !rx_empty;
  assign st_rx_full      = rx_full;
  assign st_busy         = active;
  assign st_overrun      = ovr_q;
  assign tx_irq          = irq_q;

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    cfg_enable |=> ($stable(width_q) && $stable(fmt_q) && $stable(div_q))); // R8
  AST_OVR_STICKY: assert property (@(posedge clk) disable iff (rst)
    (ovr_q && !ovr_clr) |=> ovr_q); // R11
  AST_IRQ_OFF: assert property (@(posedge clk) disable iff (rst)
    !cfg_enable |=> !irq_q); // R7
  AST_NO_START_DISABLED: assert property (@(posedge clk) disable iff (rst)
    (!cfg_enable && !active) |=> !active); // R6
endmodule

// File: tb/test_sync_serial_master.sv
module test_sync_serial_master;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rst = 1'b1;
  logic        cfg_enable = 1'b0, cfg_fmt = 1'b0;
  logic [3:0]  cfg_width_m1 = 4'd7;
  logic [7:0]  cfg_prescale = 8'd2, cfg_divider = 8'd0;
  logic        tx_wr = 1'b0, rx_rd = 1'b0, ovr_clr = 1'b0, inv = 1'b0;
  logic [15:0] tx_data = 16'h0;
  logic [15:0] rx_data;
  logic        sclk, frame_sel, sdo, sdi;
  logic        st_tx_empty, st_tx_not_full, st_rx_not_empty, st_rx_full;
  logic        st_busy, st_overrun, tx_irq;

  assign sdi = sdo ^ inv;

  sync_serial_master i_sync_serial_master (
    .clk(clk), .rst(rst), .cfg_enable(cfg_enable), .cfg_fmt(cfg_fmt),
    .cfg_width_m1(cfg_width_m1), .cfg_prescale(cfg_prescale), .cfg_divider(cfg_divider),
    .tx_wr(tx_wr), .tx_data(tx_data), .rx_rd(rx_rd), .rx_data(rx_data), .ovr_clr(ovr_clr),
    .sclk(sclk), .frame_sel(frame_sel), .sdo(sdo), .sdi(sdi),
    .st_tx_empty(st_tx_empty), .st_tx_not_full(st_tx_not_full),
    .st_rx_not_empty(st_rx_not_empty), .st_rx_full(st_rx_full),
    .st_busy(st_busy), .st_overrun(st_overrun), .tx_irq(tx_irq)
  );

  int checks = 0, errors = 0;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // serial monitor, sampled on the falling system clock edge
  logic   mon_clr = 1'b0, mode_ssi = 1'b0;
  longint cyc = 0, last_rise = 0;
  logic   prev_sclk = 1'b0, prev_sel = 1'b1, prev_busy = 1'b0, have_rise = 1'b0;
  int     rises = 0, minp = 0, maxp = 0, sel_hi = 0, sel_rises = 0, sel_bad = 0, idle_tog = 0;
  logic [15:0] cap = 16'h0;

  always @(negedge clk) begin
    cyc++;
    if (mon_clr) begin
      rises = 0; minp = 1 << 30; maxp = 0; sel_hi = 0; sel_rises = 0;
      sel_bad = 0; idle_tog = 0; cap = 16'h0; have_rise = 1'b0;
    end else begin
      if (sclk && !prev_sclk) begin
        rises++;
        if (have_rise) begin
          if (int'(cyc - last_rise) < minp) minp = int'(cyc - last_rise);
          if (int'(cyc - last_rise) > maxp) maxp = int'(cyc - last_rise);
        end
        have_rise = 1'b1;
        last_rise = cyc;
        if (!mode_ssi) begin
          cap = {cap[14:0], sdo};
          if (frame_sel) sel_bad++;
        end
      end
      if (!sclk && prev_sclk && mode_ssi && !frame_sel) cap = {cap[14:0], sdo};
      if (frame_sel) sel_hi++;
      if (frame_sel && !prev_sel) sel_rises++;
      if (!st_busy && !prev_busy && (sclk != prev_sclk)) idle_tog++;
    end
    prev_sclk = sclk;
    prev_sel  = frame_sel;
    prev_busy = st_busy;
  end

  task automatic mon_reset();
    @(posedge clk); mon_clr = 1'b1;
    @(posedge clk); mon_clr = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic f, input logic [3:0] w, input logic [7:0] p,
                         input logic [7:0] d, input logic iv);
    @(negedge clk);
    cfg_fmt = f; cfg_width_m1 = w; cfg_prescale = p; cfg_divider = d; inv = iv; mode_ssi = f;
    repeat (3) @(negedge clk);
  endtask

  task automatic push(input logic [15:0] v);
    tx_data = v; tx_wr = 1'b1;
    @(negedge clk);
    tx_wr = 1'b0;
  endtask

  task automatic pop(output logic [15:0] v);
    rx_rd = 1'b1;
    @(negedge clk);
    rx_rd = 1'b0;
    v = rx_data;
  endtask

  task automatic wait_idle();
    do @(negedge clk); while (st_busy || !st_tx_empty);
    @(negedge clk);
  endtask

  function automatic int bits_of(input logic [3:0] w);
    return (w < 4'd3) ? 4 : int'(w) + 1;
  endfunction

  function automatic int period_of(input logic [7:0] p, input logic [7:0] d);
    int pe;
    pe = int'(p) & 32'hFE;
    if (pe == 0) pe = 2;
    return pe * (1 + int'(d));
  endfunction

  task automatic one_frame(input logic f, input logic [3:0] w, input logic [7:0] p,
                           input logic [7:0] d, input logic iv, input logic [15:0] v);
    int n, t;
    logic [15:0] mask, got;
    n = bits_of(w);
    t = period_of(p, d);
    mask = 16'((32'h1 << n) - 1);
    set_cfg(f, w, p, d, iv);
    mon_reset();
    push(v);
    cfg_enable = 1'b1;
    wait_idle();
    cfg_enable = 1'b0;
    @(negedge clk);
    pop(got);
    check("R10 rx word", int'(got), int'((v ^ (iv ? 16'hFFFF : 16'h0)) & mask));
    check("R1 msb-first bits on line", int'(cap & mask), int'(v & mask));
    check(f ? "R3 sclk rises" : "R2 sclk rises", rises, f ? n + 1 : n);
    check("R5 min bit period", minp, t);
    check("R5 max bit period", maxp, t);
    check("R4 idle toggles", idle_tog, 0);
    if (f) begin
      check("R3 frame pulse length", sel_hi, t);
      check("R3 idle frame_sel", int'(frame_sel), 0);
    end else begin
      check("R2 select high at a rising edge", sel_bad, 0);
      check("R2 idle frame_sel", int'(frame_sel), 1);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [15:0] got;
    logic [15:0] words [10];
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (2) @(negedge clk);
    // reset state
    check("R2 reset sclk", int'(sclk), 0);
    check("R2 reset frame_sel", int'(frame_sel), 1);
    check("R9 reset flags", int'({st_tx_empty, st_tx_not_full, st_rx_not_empty, st_rx_full, st_busy}), 5'b11000);
    check("R11 reset overrun", int'(st_overrun), 0);
    check("R7 reset irq", int'(tx_irq), 0);

    // sweep format x width x two rates
    for (int f = 0; f < 2; f++)
      for (int w = 3; w < 16; w++)
        for (int r = 0; r < 2; r++)
          one_frame(f[0], 4'(w), r ? 8'd7 : 8'd2, r ? 8'd2 : 8'd0, w[0],
                    16'hC3A5 ^ 16'(w * 16'h1111) ^ (r ? 16'h5A5A : 16'h0));
    // divider extremes and clamped width
    one_frame(1'b0, 4'd1, 8'd255, 8'd1, 1'b0, 16'h0009);  // R1 width clamp, R5 P=254
    one_frame(1'b0, 4'd3, 8'd0, 8'd255, 1'b1, 16'h0006);  // R5 P=0 acts as 2

    // R3 / R6: SSI back to back, enabled with words already queued
    set_cfg(1'b1, 4'd4, 8'd2, 8'd0, 1'b0);
    mon_reset();
    push(16'h0011); push(16'h000A); push(16'h001F);
    cfg_enable = 1'b1;
    wait_idle();
    cfg_enable = 1'b0;
    check("R3 one pulse per word", sel_rises, 3);
    check("R3 rises for three words", rises, 18);
    pop(got); check("R6 ssi word 0", int'(got), 16'h11);
    pop(got); check("R6 ssi word 1", int'(got), 16'h0A);
    pop(got); check("R6 ssi word 2", int'(got), 16'h1F);

    // R8: configuration changes while enabled are ignored
    set_cfg(1'b0, 4'd7, 8'd2, 8'd0, 1'b0);
    mon_reset();
    cfg_enable = 1'b1;
    @(negedge clk);
    cfg_width_m1 = 4'd11; cfg_fmt = 1'b1; cfg_divider = 8'd3;
    repeat (2) @(negedge clk);
    push(16'h0F96);
    wait_idle();
    check("R8 width unchanged while enabled", rises, 8);
    check("R8 rate unchanged while enabled", maxp, 2);
    cfg_enable = 1'b0;
    @(negedge clk);
    pop(got);
    check("R8 rx uses old width", int'(got), 16'h96);

    // R6/R7/R9/R11: fill, overflow writes, receive overrun
    set_cfg(1'b0, 4'd7, 8'd4, 8'd3, 1'b0);
    mon_reset();
    cfg_enable = 1'b1;
    repeat (2) @(negedge clk);
    check("R7 irq when enabled and empty", int'(tx_irq), 1);
    for (int i = 0; i < 10; i++) begin
      words[i] = 16'(8'h31 + i * 8'h17);
      push(words[i]);
    end
    check("R9 tx full", int'(st_tx_not_full), 0);
    check("R7 irq low above level", int'(tx_irq), 0);
    wait_idle();
    check("R9 dropped write not sent", rises, 72);
    check("R2 select held across words", sel_rises, 1);
    check("R9 rx full", int'(st_rx_full), 1);
    check("R11 overrun set", int'(st_overrun), 1);
    check("R7 irq after drain", int'(tx_irq), 1);
    for (int i = 0; i < 8; i++) begin
      pop(got);
      check("R10 fifo order", int'(got), int'(words[i] & 16'hFF));
    end
    check("R9 rx empty after pops", int'(st_rx_not_empty), 0);
    check("R11 overrun sticky", int'(st_overrun), 1);
    ovr_clr = 1'b1; @(negedge clk); ovr_clr = 1'b0; @(negedge clk);
    check("R11 overrun cleared", int'(st_overrun), 0);
    cfg_enable = 1'b0;
    repeat (2) @(negedge clk);
    check("R7 irq off when disabled", int'(tx_irq), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule